// File: doc/BRIEF.md
# UART Control and Status Register Block

This block is the software-visible face of a simple UART. It is a slave on a 32-bit bus where every access is a full word and completes in one cycle. It holds the byte going out, the byte that last came in, and the enable, identification, line, modem and divisor registers, and it drives a single interrupt line. Serial shifting, bit timing and modem pins live elsewhere. A separate serializer takes the outgoing byte through a valid/done handshake, and a deserializer hands in each received byte with a one-cycle strobe.

A small two-state machine tracks the transmitter. In `TX_IDLE` the holding register is empty and `tx_valid` is low. A write to offset 0x00 takes the transition `LOAD` to `TX_BUSY`, where `tx_valid` stays high. In `TX_BUSY` a `tx_done` pulse takes the transition `FINISH` back to `TX_IDLE` and raises the completion event. A new write in `TX_BUSY` takes the transition `RELOAD`, which stays in `TX_BUSY` with the new byte. The outgoing byte is trimmed to the word length selected in line control. Register values occupy bits [7:0] of the data word, and each register sits on a word-aligned offset.

Top module: `uart_regfile`

## Requirements
- R1: After reset every register reads 0 except line status (0x14), which reads 0x20. `irq` and `tx_valid` are low.
- R2: The identification (0x08), line control (0x0C), modem control (0x10), line status (0x14), modem status (0x18), divisor (0x1C) and enable (0x04) registers take bits [7:0] of a write. They read back in bits [7:0], and bits [31:8] read as zero.
- R3: A read at any other offset, including an unaligned one, returns zero. A write there changes no register.
- R4: A write to 0x00 stores the byte, clears line status bit 5 and clears identification bit 1. From the next cycle `tx_valid` is high, and it stays high until `tx_done` is seen.
- R5: `tx_data` is the stored byte masked by line control bits [1:0]: code 0 keeps 5 bits, 1 keeps 6, 2 keeps 7 and 3 keeps 8.
- R6: `tx_done` while `tx_valid` is high ends the transmit. On the next cycle `tx_valid` is low, line status bit 5 is set, identification reads 0x02, and `irq` is set if enable bit 1 is set.
- R7: A write to 0x04 with bit 1 set while line status bit 5 is set sets identification bit 1 and raises `irq` on the next cycle. A write to 0x04 with bit 1 clear lowers `irq`.
- R8: An `rx_strobe` loads `rx_data` into the receive register and sets line status bit 0. If enable bit 0 is set, identification becomes 0x04 and `irq` rises.
- R9: A read of 0x00 returns the received byte and clears line status bit 0.
- R10: No other event lowers `irq`; in particular, reads leave it unchanged.
- R11: `tx_done` while `tx_valid` is low changes nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_sel | input | 1 | Access in this cycle |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 8 | Byte offset of the access |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid in the cycle of a read |
| tx_valid | output | 1 | Outgoing byte is waiting for the serializer |
| tx_data | output | 8 | Outgoing byte after word-length masking |
| tx_done | input | 1 | Serializer finished the byte |
| rx_strobe | input | 1 | One-cycle pulse: a byte has been received |
| rx_data | input | 8 | Received byte |
| irq | output | 1 | Interrupt request |

## Verification
The assertions assume that `tx_done`, `rx_strobe` and a bus write do not fall on the same cycle when a check concerns the identification or line status result. The completion and receive checks exclude such coincidences explicitly. The stimulus keeps to this by driving one event per cycle and leaving a full bus access between handshake pulses. Random word-length codes and bytes exercise the masking and the completion path. Random register writes use values over the whole 32-bit range, so that the high bits are seen to be dropped.

// File: rtl/uart_regfile_pkg.sv
package uart_regfile_pkg;
    localparam int OFF_DATA = 'h00;
    localparam int OFF_IER  = 'h04;
    localparam int OFF_IIR  = 'h08;
    localparam int OFF_LCR  = 'h0C;
    localparam int OFF_MCR  = 'h10;
    localparam int OFF_LSR  = 'h14;
    localparam int OFF_MSR  = 'h18;
    localparam int OFF_DIV  = 'h1C;

    localparam logic [7:0] LSR_RESET = 8'h20;
    localparam logic [7:0] IIR_TXRDY = 8'h02;
    localparam logic [7:0] IIR_RXRDY = 8'h04;

    localparam int LSR_RXBIT = 0;
    localparam int LSR_TXBIT = 5;
    localparam int IER_RXBIT = 0;
    localparam int IER_TXBIT = 1;
    localparam int IIR_TXBIT = 1;

    typedef enum logic {
        TX_IDLE,
        TX_BUSY
    } tx_state_e;
endpackage

// File: rtl/uart_tx_fsm.sv
module uart_tx_fsm
    import uart_regfile_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic load_i,
    input  logic done_i,
    output logic valid_o,
    output logic complete_o
);
    tx_state_e state_q, state_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= TX_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            TX_IDLE: if (load_i) state_d = TX_BUSY;                  // LOAD
            TX_BUSY: begin
                if (load_i)      state_d = TX_BUSY;                  // RELOAD
                else if (done_i) state_d = TX_IDLE;                  // FINISH
            end
            default: state_d = TX_IDLE;
        endcase
    end

    always_comb begin
        valid_o    = (state_q == TX_BUSY);
        complete_o = (state_q == TX_BUSY) && done_i;
    end
endmodule

// File: rtl/uart_len_mask.sv
module uart_len_mask #(
    parameter int CHAR_W = 8,
    parameter int MIN_W  = 5
) (
    input  logic [CHAR_W-1:0] char_i,
    input  logic [1:0]        len_i,
    output logic [CHAR_W-1:0] char_o
);
    logic [CHAR_W:0] keep_mask;

    always_comb begin
        keep_mask = ((CHAR_W+1)'(1) << (MIN_W + int'(len_i))) - (CHAR_W+1)'(1);
        char_o    = char_i & keep_mask[CHAR_W-1:0];
    end
endmodule

// File: rtl/uart_regfile.sv
module uart_regfile
    import uart_regfile_pkg::*;
#(
    parameter int ADDR_W = 8,
    parameter int DATA_W = 32,
    parameter int REG_W  = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_sel,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    output logic              tx_valid,
    output logic [REG_W-1:0]  tx_data,
    input  logic              tx_done,
    input  logic              rx_strobe,
    input  logic [REG_W-1:0]  rx_data,
    output logic              irq
);
    localparam logic [ADDR_W-1:0] A_DATA = ADDR_W'(OFF_DATA);
    localparam logic [ADDR_W-1:0] A_IER  = ADDR_W'(OFF_IER);
    localparam logic [ADDR_W-1:0] A_IIR  = ADDR_W'(OFF_IIR);
    localparam logic [ADDR_W-1:0] A_LCR  = ADDR_W'(OFF_LCR);
    localparam logic [ADDR_W-1:0] A_MCR  = ADDR_W'(OFF_MCR);
    localparam logic [ADDR_W-1:0] A_LSR  = ADDR_W'(OFF_LSR);
    localparam logic [ADDR_W-1:0] A_MSR  = ADDR_W'(OFF_MSR);
    localparam logic [ADDR_W-1:0] A_DIV  = ADDR_W'(OFF_DIV);

    logic [REG_W-1:0] rbr_q, thr_q, ier_q, iir_q, lcr_q, mcr_q, lsr_q, msr_q, div_q;
    logic [REG_W-1:0] rbr_d, thr_d, ier_d, iir_d, lcr_d, mcr_d, lsr_d, msr_d, div_d;
    logic             irq_q, irq_d;
    logic             wr_en, rd_en, thr_load, tx_complete;
    logic [REG_W-1:0] wbyte, rd_byte;
    logic             unused_wdata_hi;

    assign wr_en           = bus_sel && bus_wr;
    assign rd_en           = bus_sel && !bus_wr;
    assign wbyte           = bus_wdata[REG_W-1:0];
    assign thr_load        = wr_en && (bus_addr == A_DATA);
    assign unused_wdata_hi = ^bus_wdata[DATA_W-1:REG_W];

    uart_tx_fsm u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .load_i     (thr_load),
        .done_i     (tx_done),
        .valid_o    (tx_valid),
        .complete_o (tx_complete)
    );

    uart_len_mask #(.CHAR_W(REG_W)) u_mask (
        .char_i (thr_q),
        .len_i  (lcr_q[1:0]),
        .char_o (tx_data)
    );

    always_comb begin
        rbr_d = rbr_q; thr_d = thr_q; ier_d = ier_q; iir_d = iir_q;
        lcr_d = lcr_q; mcr_d = mcr_q; lsr_d = lsr_q; msr_d = msr_q;
        div_d = div_q; irq_d = irq_q;

        if (tx_complete) begin
            lsr_d[LSR_TXBIT] = 1'b1;
            iir_d            = IIR_TXRDY;
            if (ier_q[IER_TXBIT]) irq_d = 1'b1;
        end

        if (wr_en) begin
            case (bus_addr)
                A_DATA: begin
                    thr_d            = wbyte;
                    lsr_d[LSR_TXBIT] = 1'b0;
                    iir_d[IIR_TXBIT] = 1'b0;
                end
                A_IER: begin
                    ier_d = wbyte;
                    if (wbyte[IER_TXBIT] && lsr_d[LSR_TXBIT]) begin
                        iir_d[IIR_TXBIT] = 1'b1;
                        irq_d            = 1'b1;
                    end else if (!wbyte[IER_TXBIT]) begin
                        irq_d = 1'b0;
                    end
                end
                A_IIR:   iir_d = wbyte;
                A_LCR:   lcr_d = wbyte;
                A_MCR:   mcr_d = wbyte;
                A_LSR:   lsr_d = wbyte;
                A_MSR:   msr_d = wbyte;
                A_DIV:   div_d = wbyte;
                default: ;
            endcase
        end

        if (rd_en && (bus_addr == A_DATA)) lsr_d[LSR_RXBIT] = 1'b0;

        if (rx_strobe) begin
            rbr_d            = rx_data;
            lsr_d[LSR_RXBIT] = 1'b1;
            if (ier_q[IER_RXBIT]) begin
                iir_d = IIR_RXRDY;
                irq_d = 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rbr_q <= '0; thr_q <= '0; ier_q <= '0; iir_q <= '0;
            lcr_q <= '0; mcr_q <= '0; lsr_q <= LSR_RESET; msr_q <= '0;
            div_q <= '0; irq_q <= 1'b0;
        end else begin
            rbr_q <= rbr_d; thr_q <= thr_d; ier_q <= ier_d; iir_q <= iir_d;
            lcr_q <= lcr_d; mcr_q <= mcr_d; lsr_q <= lsr_d; msr_q <= msr_d;
            div_q <= div_d; irq_q <= irq_d;
        end
    end

    always_comb begin
        case (bus_addr)
            A_DATA:  rd_byte = rbr_q;
            A_IER:   rd_byte = ier_q;
            A_IIR:   rd_byte = iir_q;
            A_LCR:   rd_byte = lcr_q;
            A_MCR:   rd_byte = mcr_q;
            A_LSR:   rd_byte = lsr_q;
            A_MSR:   rd_byte = msr_q;
            A_DIV:   rd_byte = div_q;
            default: rd_byte = '0;
        endcase
        bus_rdata = rd_en ? DATA_W'(rd_byte) : '0;
    end

    assign irq = irq_q;
endmodule

// File: rtl/uart_regfile_chk.sv
module uart_regfile_chk #(
    parameter int ADDR_W = 8,
    parameter int DATA_W = 32
) (
    input logic              clk,
    input logic              rst_n,
    input logic              bus_sel,
    input logic              bus_wr,
    input logic [ADDR_W-1:0] bus_addr,
    input logic              wbit_tx,
    input logic [DATA_W-1:0] bus_rdata,
    input logic              tx_valid,
    input logic [7:0]        tx_data,
    input logic              tx_done,
    input logic              rx_strobe,
    input logic              irq,
    input logic [7:0]        lsr_q,
    input logic [7:0]        iir_q,
    input logic [7:0]        lcr_q,
    input logic [7:0]        ier_q
);
    logic thr_wr, ier_wr;
    assign thr_wr = bus_sel && bus_wr && (bus_addr == ADDR_W'(0));
    assign ier_wr = bus_sel && bus_wr && (bus_addr == ADDR_W'(4));

    // R4
    thr_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        thr_wr |=> (tx_valid && !lsr_q[5]));

    // R4
    valid_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_valid && !tx_done) |=> tx_valid);

    // R6
    tx_finish_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_valid && tx_done && !bus_sel && !rx_strobe)
        |=> (!tx_valid && lsr_q[5] && iir_q == 8'h02));

    // R8
    rx_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rx_strobe |=> lsr_q[0]);

    // R7
    ier_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ier_wr && !wbit_tx && !(rx_strobe && ier_q[0])) |=> !irq);

    // R5
    mask5_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (lcr_q[1:0] == 2'b00) |-> (tx_data[7:5] == 3'b000));

    // R3
    unaligned_rd_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_sel && !bus_wr && bus_addr[1:0] != 2'b00) |-> (bus_rdata == '0));

    // R11
    idle_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!tx_valid && tx_done && !bus_sel) |=> !tx_valid);
endmodule

bind uart_regfile uart_regfile_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_sel   (bus_sel),
    .bus_wr    (bus_wr),
    .bus_addr  (bus_addr),
    .wbit_tx   (bus_wdata[1]),
    .bus_rdata (bus_rdata),
    .tx_valid  (tx_valid),
    .tx_data   (tx_data),
    .tx_done   (tx_done),
    .rx_strobe (rx_strobe),
    .irq       (irq),
    .lsr_q     (lsr_q),
    .iir_q     (iir_q),
    .lcr_q     (lcr_q),
    .ier_q     (ier_q)
);

// File: tb/uart_regfile_tb.sv
`timescale 1ns/1ps
module uart_regfile_tb;
    localparam logic [7:0] A_DATA = 8'h00, A_IER = 8'h04, A_IIR = 8'h08, A_LCR = 8'h0C,
                           A_MCR = 8'h10, A_LSR = 8'h14, A_MSR = 8'h18, A_DIV = 8'h1C;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_sel = 1'b0, bus_wr = 1'b0;
    logic [7:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        tx_valid, irq;
    logic [7:0]  tx_data;
    logic        tx_done = 1'b0, rx_strobe = 1'b0;
    logic [7:0]  rx_data = '0;
    int checks = 0, errors = 0;

    always #2 clk = ~clk;

    uart_regfile u_dut (
        .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .tx_valid(tx_valid), .tx_data(tx_data), .tx_done(tx_done),
        .rx_strobe(rx_strobe), .rx_data(rx_data), .irq(irq)
    );

    function automatic logic [7:0] exp_mask(input logic [7:0] c, input logic [1:0] len);
        int m;
        m = (1 << (5 + int'(len))) - 1;
        return c & m[7:0];
    endfunction

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_sel = 1'b0; bus_wr = 1'b0;
    endtask

    task automatic rd(input logic [7:0] a, output logic [31:0] d);
        @(negedge clk);
        bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = a;
        #1 d = bus_rdata;
        @(negedge clk);
        bus_sel = 1'b0;
    endtask

    task automatic pulse_done();
        @(negedge clk); tx_done = 1'b1;
        @(negedge clk); tx_done = 1'b0;
    endtask

    task automatic pulse_rx(input logic [7:0] d);
        @(negedge clk); rx_strobe = 1'b1; rx_data = d;
        @(negedge clk); rx_strobe = 1'b0;
    endtask

    task automatic finish_run();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    endtask

    initial begin
        #(4 * 150000);
        checks++; errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        logic [31:0] v;
        logic [7:0]  addrs [5];
        void'($urandom(32'd4242));
        addrs[0] = A_IIR; addrs[1] = A_LCR; addrs[2] = A_MCR; addrs[3] = A_MSR; addrs[4] = A_DIV;

        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1 reset state
        chk("R1 irq", {31'b0, irq}, 0);
        chk("R1 tx_valid", {31'b0, tx_valid}, 0);
        for (int i = 0; i < 8; i++) begin
            rd(8'(i * 4), v);
            chk("R1 reset value", v, (i == 5) ? 32'h20 : 32'h0);
        end

        // R2 random register writes with full-width data
        for (int i = 0; i < 16; i++) begin
            logic [7:0]  a;
            logic [31:0] d;
            a = addrs[$urandom % 5];
            d = $urandom;
            wr(a, d);
            rd(a, v);
            chk("R2 readback", v, {24'b0, d[7:0]});
        end
        wr(A_LSR, 32'hFFFF_FF61);
        rd(A_LSR, v);
        chk("R2 lsr direct", v, 32'h61);
        wr(A_LSR, 32'h20);
        wr(A_IER, 32'hABCD_0000);
        rd(A_IER, v);
        chk("R2 ier", v, 32'h0);

        // R3 undefined offsets
        wr(A_LCR, 32'h3);
        wr(8'h20, 32'hFF);
        wr(8'h0D, 32'h0);
        wr(8'hFC, 32'h55);
        rd(8'h0D, v); chk("R3 unaligned read", v, 0);
        rd(8'h20, v); chk("R3 hole read", v, 0);
        rd(8'hFC, v); chk("R3 top read", v, 0);
        rd(A_LCR, v); chk("R3 lcr untouched", v, 32'h3);

        // R7 immediate interrupt when transmitter already empty
        wr(A_IIR, 32'h0);
        wr(A_IER, 32'h2);
        chk("R7 immediate irq", {31'b0, irq}, 1);
        rd(A_IIR, v); chk("R7 iir txrdy", v, 32'h02);
        wr(A_IER, 32'h0);
        chk("R7 irq cleared", {31'b0, irq}, 0);

        // R4 transmit load
        wr(A_IIR, 32'h6);
        wr(A_DATA, 32'h0000_00A5);
        chk("R4 tx_valid", {31'b0, tx_valid}, 1);
        chk("R4 tx_data", {24'b0, tx_data}, 32'hA5);
        rd(A_LSR, v); chk("R4 lsr empty cleared", v, 32'h00);
        rd(A_IIR, v); chk("R4 iir bit1 cleared", v, 32'h04);

        // R5 word-length masking
        for (int l = 0; l < 4; l++) begin
            wr(A_LCR, 32'(l));
            chk("R5 mask", {24'b0, tx_data}, {24'b0, exp_mask(8'hA5, 2'(l))});
        end
        repeat (5) @(negedge clk);
        chk("R4 valid held", {31'b0, tx_valid}, 1);

        // R7 enable while busy: no immediate interrupt
        wr(A_IER, 32'h2);
        chk("R7 no irq while busy", {31'b0, irq}, 0);
        rd(A_IIR, v); chk("R7 iir unchanged", v, 32'h04);

        // R6 completion
        pulse_done();
        chk("R6 valid low", {31'b0, tx_valid}, 0);
        chk("R6 irq", {31'b0, irq}, 1);
        rd(A_LSR, v); chk("R6 lsr", v, 32'h20);
        rd(A_IIR, v); chk("R6 iir", v, 32'h02);
        chk("R10 irq after reads", {31'b0, irq}, 1);

        // R11 stray done while idle
        wr(A_IER, 32'h0);
        wr(A_IIR, 32'h0);
        pulse_done();
        chk("R11 valid", {31'b0, tx_valid}, 0);
        rd(A_IIR, v); chk("R11 iir", v, 32'h0);
        rd(A_LSR, v); chk("R11 lsr", v, 32'h20);

        // R8/R9 receive without interrupt
        pulse_rx(8'h3C);
        rd(A_LSR, v); chk("R8 lsr rx", v, 32'h21);
        chk("R8 no irq", {31'b0, irq}, 0);
        rd(A_IIR, v); chk("R8 iir kept", v, 32'h0);
        rd(A_DATA, v); chk("R9 rbr", v, 32'h3C);
        rd(A_LSR, v); chk("R9 lsr cleared", v, 32'h20);

        // R8 receive with interrupt
        wr(A_IER, 32'h1);
        pulse_rx(8'h81);
        chk("R8 irq", {31'b0, irq}, 1);
        rd(A_IIR, v); chk("R8 iir rxrdy", v, 32'h04);
        rd(A_DATA, v); chk("R9 rbr 2", v, 32'h81);
        chk("R10 irq held", {31'b0, irq}, 1);

        // R5/R6 random transmits
        for (int i = 0; i < 12; i++) begin
            logic [1:0] l;
            logic [7:0] c;
            l = 2'($urandom);
            c = 8'($urandom);
            wr(A_LCR, {30'b0, l});
            wr(A_DATA, {24'b0, c});
            chk("R5 random mask", {24'b0, tx_data}, {24'b0, exp_mask(c, l)});
            pulse_done();
            rd(A_LSR, v); chk("R6 random lsr", v & 32'h20, 32'h20);
        end

        finish_run();
    end
endmodule